// File: doc/BRIEF.md
# Overlay Read Timeout Monitor

This block sits beside a memory-overlay unit and watches each read the overlay unit issues on the system bus. When another bus master holds the same memory, an overlay read can stall without end. The monitor counts bus clock cycles from the moment a read is accepted. If the read is still open when the cycle budget runs out, the monitor drops the read, raises an abort toward the processor, and sets a sticky flag.

The abort is a one-cycle pulse. It carries a qualifier that separates an instruction-fetch stall (prefetch abort) from a data-read stall (data abort). The qualifier is captured when the read is accepted. Software turns the monitor on by writing a 4-bit key into the control register. An abort handler reads the flag to learn whether the abort came from overlay contention. It then clears the flag by writing a one to it, so that later, unrelated aborts are not blamed on a timeout.

Top module: `ovl_timeout_mon`

## Requirements
- R1: After reset, the control register reads 0, the flag register reads 0, and both `abort_o` and `abort_fetch_o` are low.
- R2: The timeout is armed only while control bits [3:0] hold 4'b1010. With any other value, a stalled read never produces an abort and never sets the flag.
- R3: The control register is at offset 0x0. Its bits [3:0] read back what was last written there, and bits [31:4] read as 0.
- R4: A read is accepted on a rising edge where `rd_req_valid` is high and no read is open. If `rd_req_done` is not high on any of the next LIMIT (32) rising edges and the monitor is armed, `abort_o` is high for exactly one cycle, following the LIMIT-th edge.
- R5: If `rd_req_done` is high on any of those LIMIT edges, including the LIMIT-th, the read completes and no abort occurs.
- R6: `abort_fetch_o` is 1 while `abort_o` is high if the read was accepted with `rd_req_fetch`=1 (prefetch abort), and 0 if it was accepted with `rd_req_fetch`=0 (data abort). It is 0 whenever `abort_o` is low.
- R7: A timeout sets the flag, which reads at offset 0xC bit 0. The flag stays set until software clears it.
- R8: Writing 1 to bit 0 at offset 0xC clears the flag. Writing 0 there leaves the flag unchanged.
- R9: If a clear write and a timeout happen on the same edge, the flag ends up set.
- R10: While a read is open, `rd_req_valid` is ignored: it neither restarts the count nor changes the captured type. After a timeout the monitor is idle and accepts the next read.
- R11: Offsets 0x4 and 0x8 read as 0, and writes to them change neither register.
- R12: While disarmed, the cycle count of an open read stops at its limit. Arming the monitor later causes the abort on the first edge after the arming write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_valid | input | 1 | Overlay read request presented |
| rd_req_fetch | input | 1 | 1 = instruction fetch, 0 = data read |
| rd_req_done | input | 1 | The open read completes on this edge |
| csr_addr | input | ADDR_W (4) | Register byte offset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | DATA_W (32) | Register write data |
| csr_rdata | output | DATA_W (32) | Register read data (combinational from `csr_addr`) |
| abort_o | output | 1 | One-cycle abort pulse |
| abort_fetch_o | output | 1 | Abort class: 1 = prefetch, 0 = data |

## Verification
The bench builds the monitor with its default parameters: a 32-cycle budget, a 4-bit offset bus and a 32-bit data bus. The 32-cycle budget brings the exact boundary within reach, so the bench compares completion on the 32nd edge with completion one edge later. The 4-bit offset reaches both mapped registers and the two unmapped words between them. With 32-bit data, the bench can confirm that the upper control bits read as zero and that every key other than 1010 leaves the monitor disarmed.

// File: rtl/ovl_tmo_pkg.sv
package ovl_tmo_pkg;
  localparam int unsigned KEY_W    = 4;
  localparam logic [KEY_W-1:0] ARM_KEY = 4'b1010;
  localparam int unsigned OFF_CTRL = 32'h0;
  localparam int unsigned OFF_FLAG = 32'hC;

  typedef enum logic [0:0] {
    TRK_IDLE = 1'b0,
    TRK_WAIT = 1'b1
  } trk_state_e;
endpackage

// File: rtl/ovl_tmo_rst_sync.sv
module ovl_tmo_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ovl_tmo_tracker.sv
module ovl_tmo_tracker
  import ovl_tmo_pkg::*;
#(
  parameter int unsigned LIMIT = 32,
  localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic req_valid,
  input  logic req_fetch,
  input  logic req_done,
  output logic busy_o,
  output logic tmo_o,
  output logic tmo_fetch_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  trk_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             fetch_q;
  logic             cap_en;
  logic             at_limit;

  assign at_limit = (cnt_q == LAST);
  assign tmo_o    = (state_q == TRK_WAIT) && !req_done && armed && at_limit;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      TRK_IDLE: begin
        if (req_valid) begin
          state_d = TRK_WAIT;
          cnt_d   = '0;
          cnt_en  = 1'b1;
          cap_en  = 1'b1;
        end
      end
      TRK_WAIT: begin
        if (req_done || tmo_o) begin
          state_d = TRK_IDLE;
        end else if (!at_limit) begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = TRK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TRK_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fetch_q <= 1'b0;
    else if (cap_en) fetch_q <= req_fetch;
  end

  assign busy_o      = (state_q == TRK_WAIT);
  assign tmo_fetch_o = fetch_q;
endmodule

// File: rtl/ovl_tmo_regs.sv
module ovl_tmo_regs
  import ovl_tmo_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_we,
  input  logic [DATA_W-1:0] csr_wdata,
  input  logic              tmo_set,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              armed_o,
  output logic              flag_o
);
  logic             hit_ctrl, hit_flag;
  logic             ctrl_en;
  logic [KEY_W-1:0] ctrl_q, ctrl_d;
  logic             flag_q, flag_d, flag_clr;
  logic             wdata_unused;

  assign hit_ctrl = (csr_addr == ADDR_W'(OFF_CTRL));
  assign hit_flag = (csr_addr == ADDR_W'(OFF_FLAG));

  assign ctrl_en  = csr_we && hit_ctrl;
  assign ctrl_d   = csr_wdata[KEY_W-1:0];
  assign flag_clr = csr_we && hit_flag && csr_wdata[0];
  assign flag_d   = tmo_set | (flag_q & ~flag_clr);
  assign wdata_unused = ^csr_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_comb begin
    csr_rdata = '0;
    if (hit_ctrl)      csr_rdata = DATA_W'(ctrl_q);
    else if (hit_flag) csr_rdata = DATA_W'(flag_q);
  end

  assign armed_o = (ctrl_q == ARM_KEY);
  assign flag_o  = flag_q;
endmodule

// File: rtl/ovl_tmo_abort_out.sv
module ovl_tmo_abort_out (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo,
  input  logic tmo_fetch,
  output logic abort_o,
  output logic abort_fetch_o
);
  logic abort_q, abort_d;
  logic kind_q, kind_d;

  assign abort_d = tmo;
  assign kind_d  = tmo & tmo_fetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
      kind_q  <= 1'b0;
    end else begin
      abort_q <= abort_d;
      kind_q  <= kind_d;
    end
  end

  assign abort_o       = abort_q;
  assign abort_fetch_o = kind_q;
endmodule

// File: rtl/ovl_timeout_mon.sv
module ovl_timeout_mon #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LIMIT  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_valid,
  input  logic              rd_req_fetch,
  input  logic              rd_req_done,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_we,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              abort_o,
  output logic              abort_fetch_o
);
  logic rst_core_n;
  logic armed;
  logic to_flag;
  logic busy;
  logic tmo;
  logic tmo_fetch;

  ovl_tmo_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  ovl_tmo_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .csr_addr  (csr_addr),
    .csr_we    (csr_we),
    .csr_wdata (csr_wdata),
    .tmo_set   (tmo),
    .csr_rdata (csr_rdata),
    .armed_o   (armed),
    .flag_o    (to_flag)
  );

  ovl_tmo_tracker #(.LIMIT(LIMIT)) u_trk (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .armed       (armed),
    .req_valid   (rd_req_valid),
    .req_fetch   (rd_req_fetch),
    .req_done    (rd_req_done),
    .busy_o      (busy),
    .tmo_o       (tmo),
    .tmo_fetch_o (tmo_fetch)
  );

  ovl_tmo_abort_out u_abt (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .tmo           (tmo),
    .tmo_fetch     (tmo_fetch),
    .abort_o       (abort_o),
    .abort_fetch_o (abort_fetch_o)
  );
endmodule

// File: rtl/ovl_tmo_chk.sv
module ovl_tmo_chk
  import ovl_tmo_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abort_o,
  input logic              abort_fetch_o,
  input logic              to_flag,
  input logic              armed,
  input logic              busy,
  input logic              csr_we,
  input logic [ADDR_W-1:0] csr_addr,
  input logic              clr_bit
);
  // R4: the abort is a single-cycle pulse
  a_r4_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);

  // R6: no class bit without an abort
  a_r6_kind_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_o |-> !abort_fetch_o);

  // R2: an abort only follows a cycle in which the key was in place
  a_r2_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_o) |-> $past(armed));

  // R7: every abort is recorded in the flag
  a_r7_flag_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> to_flag);

  // R8: the flag only falls after a write of one to its offset
  a_r8_flag_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(to_flag) |-> $past(csr_we && (csr_addr == ADDR_W'(OFF_FLAG)) && clr_bit));

  // R10: after a timeout the tracker is idle
  a_r10_idle_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !busy);
endmodule

bind ovl_timeout_mon ovl_tmo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .abort_o       (abort_o),
  .abort_fetch_o (abort_fetch_o),
  .to_flag       (to_flag),
  .armed         (armed),
  .busy          (busy),
  .csr_we        (csr_we),
  .csr_addr      (csr_addr),
  .clr_bit       (csr_wdata[0])
);

// File: tb/ovl_timeout_mon_tb.sv
module ovl_timeout_mon_tb;
  localparam int LIMIT = 32;
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_FLAG = 4'hC;

  logic        clk;
  logic        rst_n;
  logic        rd_req_valid, rd_req_fetch, rd_req_done;
  logic [3:0]  csr_addr;
  logic        csr_we;
  logic [31:0] csr_wdata, csr_rdata;
  logic        abort_o, abort_fetch_o;

  int checks = 0;
  int failures = 0;

  ovl_timeout_mon u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_req_valid(rd_req_valid), .rd_req_fetch(rd_req_fetch), .rd_req_done(rd_req_done),
    .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .abort_o(abort_o), .abort_fetch_o(abort_fetch_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [3:0] key;
    logic [6:0] lat;    // edge carrying done; 0 = never
    logic       fetch;
    logic       exp_abort;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'hA, 7'd5,  1'b1, 1'b0},
    '{4'hA, 7'd32, 1'b0, 1'b0},
    '{4'hA, 7'd0,  1'b1, 1'b1},
    '{4'hA, 7'd0,  1'b0, 1'b1},
    '{4'hA, 7'd33, 1'b1, 1'b1},
    '{4'hB, 7'd0,  1'b1, 1'b0},
    '{4'h5, 7'd0,  1'b0, 1'b0},
    '{4'h0, 7'd0,  1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic csr_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    @(posedge clk); #1;
    csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  // Accepts a read, then walks 40 edges; reports abort count, edge and class.
  task automatic run_req(input bit f, input int lat, input int dup_k, input int clr_k,
                         output int n, output int at, output bit ty);
    n = 0; at = 0; ty = 1'b0;
    @(negedge clk);
    rd_req_valid = 1'b1; rd_req_fetch = f;
    @(posedge clk); #1;
    rd_req_valid = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      rd_req_done  = (k == lat);
      rd_req_valid = (k == dup_k);
      rd_req_fetch = (k == dup_k) ? ~f : f;
      csr_we       = (k == clr_k);
      csr_addr     = A_FLAG;
      csr_wdata    = 32'h1;
      @(posedge clk); #1;
      if (abort_o) begin n++; at = k; ty = abort_fetch_o; end
    end
    @(negedge clk);
    rd_req_done = 1'b0; rd_req_valid = 1'b0; csr_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int n, at;
    bit ty;
    rst_n = 1'b0; rd_req_valid = 1'b0; rd_req_fetch = 1'b0; rd_req_done = 1'b0;
    csr_addr = '0; csr_we = 1'b0; csr_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    csr_read(A_CTRL, rd); chk(rd == 0, "R1", "ctrl after reset", rd, 0);
    csr_read(A_FLAG, rd); chk(rd == 0, "R1", "flag after reset", rd, 0);
    chk(!abort_o && !abort_fetch_o, "R1", "abort after reset", {abort_o, abort_fetch_o}, 0);

    // Table walk: R2 R4 R5 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      csr_write(A_CTRL, {28'h0, VECS[i].key});
      run_req(VECS[i].fetch, int'(VECS[i].lat), 0, 0, n, at, ty);
      if (VECS[i].exp_abort) begin
        chk(n == 1, "R4", $sformatf("vec%0d abort count", i), n, 1);
        chk(at == LIMIT, "R4", $sformatf("vec%0d abort edge", i), at, LIMIT);
        chk(ty == VECS[i].fetch, "R6", $sformatf("vec%0d abort class", i), ty, VECS[i].fetch);
      end else begin
        chk(n == 0, (VECS[i].key == 4'hA) ? "R5" : "R2", $sformatf("vec%0d no abort", i), n, 0);
      end
      csr_read(A_FLAG, rd);
      chk(rd == {31'h0, VECS[i].exp_abort}, "R7", $sformatf("vec%0d flag", i), rd, VECS[i].exp_abort);
      csr_write(A_FLAG, 32'h1);
      csr_read(A_FLAG, rd);
      chk(rd == 0, "R8", $sformatf("vec%0d flag cleared", i), rd, 0);
    end

    // R3: upper control bits read zero
    csr_write(A_CTRL, 32'hFFFF_FFFA);
    csr_read(A_CTRL, rd); chk(rd == 32'hA, "R3", "ctrl readback", rd, 32'hA);

    // R11: unmapped offsets
    csr_write(4'h4, 32'hFFFF_FFFF);
    csr_write(4'h8, 32'h1);
    csr_read(4'h4, rd); chk(rd == 0, "R11", "offset 4 read", rd, 0);
    csr_read(4'h8, rd); chk(rd == 0, "R11", "offset 8 read", rd, 0);
    csr_read(A_CTRL, rd); chk(rd == 32'hA, "R11", "ctrl untouched", rd, 32'hA);

    // R10: a second valid during an open read is ignored; idle afterwards
    run_req(1'b1, 0, 10, 0, n, at, ty);
    chk(n == 1 && at == LIMIT, "R10", "abort edge despite second valid", at, LIMIT);
    chk(ty == 1'b1, "R10", "class kept from first read", ty, 1);
    run_req(1'b0, 0, 0, 0, n, at, ty);
    chk(n == 1 && at == LIMIT && ty == 1'b0, "R10", "next read after timeout", {n[7:0], at[7:0]}, {8'd1, 8'd32});

    // R7 sticky, R8 write of zero has no effect
    csr_write(A_FLAG, 32'h0);
    csr_read(A_FLAG, rd); chk(rd == 1, "R8", "write 0 keeps flag", rd, 1);
    repeat (5) @(posedge clk);
    csr_read(A_FLAG, rd); chk(rd == 1, "R7", "flag sticky", rd, 1);
    csr_write(A_FLAG, 32'h1);

    // R9: clear on the timeout edge leaves the flag set
    run_req(1'b0, 0, 0, LIMIT, n, at, ty);
    chk(n == 1, "R9", "abort with clear", n, 1);
    csr_read(A_FLAG, rd); chk(rd == 1, "R9", "flag set wins over clear", rd, 1);
    csr_write(A_FLAG, 32'h1);

    // R12: count stops at the limit while disarmed; arming fires next edge
    csr_write(A_CTRL, 32'h0);
    run_req(1'b1, 0, 0, 0, n, at, ty);
    chk(n == 0, "R12", "disarmed no abort", n, 0);
    csr_write(A_CTRL, 32'hA);
    chk(abort_o == 1'b0, "R12", "no abort on arming edge", abort_o, 0);
    @(posedge clk); #1;
    chk(abort_o == 1'b1, "R12", "abort one edge after arming", abort_o, 1);
    chk(abort_fetch_o == 1'b1, "R12", "class of saturated read", abort_fetch_o, 1);
    @(posedge clk); #1;
    chk(abort_o == 1'b0, "R4", "pulse ends", abort_o, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule